// File: doc/BRIEF.md
# Integer Adder-Subtractor with NZVC Status Flags

This block adds or subtracts two integers of a configurable width and keeps four status flags: negative (N), zero (Z), signed overflow (V) and carry (C). Subtraction uses the same adder as addition. The B operand is inverted bitwise and the carry-in is forced high, so the unit computes A + ~B + 1. The result bits do not depend on whether the operands are read as signed or unsigned. Only V and C differ between the two readings: V reports signed overflow and C reports unsigned overflow or borrow.

Two chained operations use the stored carry flag as carry-in. Add-with-carry and subtract-with-borrow let a caller build a sum or difference wider than the datapath out of several single-width operations, starting with the least significant word. A static mode input sets what C means after a subtract. In one mode C = 1 signals a borrow. In the other mode C = 1 signals that no borrow occurred. Subtract-with-borrow reads the stored flag under the same meaning.

The block has no sequencing state machine. Each issued operation is a single registered step, and its result and flags can be read on the next cycle.

Top module: `addsub_nzvc`

## Requirements
- R1: With op_code 2'b00 (ADD), the result one cycle after issue is (A + B) mod 2^W, and C is the carry out of the most significant bit, so C = 1 exactly when the unsigned sum exceeds 2^W - 1.
- R2: With op_code 2'b10 (SUB), the result is (A - B) mod 2^W. Let "borrow" mean that A < B as unsigned values. When borrow_mode = 0, C is set to NOT borrow. When borrow_mode = 1, C is set to borrow.
- R3: V is set exactly when the true signed (two's complement) result of the operation, including the carry-in, lies outside the range -2^(W-1) to 2^(W-1) - 1.
- R4: N equals the most significant bit of the new result, and Z is 1 exactly when every bit of the new result is 0.
- R5: With op_code 2'b01 (ADC), the stored C is added as carry-in. An ADD on the low words followed by an ADC on the high words produces the double-width sum.
- R6: With op_code 2'b11 (SBB), the stored C acts as an incoming borrow, read under the current borrow_mode. An incoming borrow subtracts one more from the result. A SUB followed by an SBB produces the double-width difference in either mode.
- R7: An operation issued with flag_we = 0 updates the result but leaves N, Z, V and C unchanged.
- R8: While op_valid = 0, the result and all four flags hold their values.
- R9: Reset (rst_n low) clears the result and all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issues an operation this cycle |
| op_code | input | 2 | 00 ADD, 01 ADC, 10 SUB, 11 SBB |
| flag_we | input | 1 | Allows the issued operation to write the flags |
| borrow_mode | input | 1 | 1: C = 1 means borrow after a subtract; 0: C = 1 means no borrow |
| opa | input | W | Operand A |
| opb | input | W | Operand B |
| result | output | W | Registered result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The hardest case to reach from the ports is a subtract-with-borrow whose carry-in comes from a flag stored under the opposite polarity convention. Every SBB path depends on the stored C written by the operation before it. The stimulus therefore runs a full SUB-then-SBB double-width chain once in each borrow_mode, and chooses low words that force a borrow so the chain is actually exercised. Signed overflow is reached with operands at the edges of the signed range: 0x7F + 0x01 and 0x80 - 0x01.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;

endpackage

// File: rtl/addsub_opsel.sv
// Operand conditioning: picks the B polarity and the carry-in for each operation.
module addsub_opsel
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   opb,
    input  logic           c_flag,
    input  logic           borrow_mode,
    output logic [W-1:0]   b_eff,
    output logic           cin,
    output logic           is_sub
);

    always_comb begin
        unique case (op)
            OP_ADD: begin
                b_eff  = opb;
                cin    = 1'b0;
                is_sub = 1'b0;
            end
            OP_ADC: begin
                b_eff  = opb;
                cin    = c_flag;
                is_sub = 1'b0;
            end
            OP_SUB: begin
                b_eff  = ~opb;
                cin    = 1'b1;
                is_sub = 1'b1;
            end
            OP_SBB: begin
                b_eff  = ~opb;
                // stored flag means borrow when borrow_mode=1: no carry-in then
                cin    = borrow_mode ? ~c_flag : c_flag;
                is_sub = 1'b1;
            end
            default: begin
                b_eff  = opb;
                cin    = 1'b0;
                is_sub = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/addsub_ripple.sv
// Bit-level ripple adder that exposes the carry into and out of the sign bit.
module addsub_ripple #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_into_msb,
    output logic         c_out
);

    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign c_into_msb = carry[W-1];
    assign c_out      = carry[W];

endmodule

// File: rtl/addsub_flagcalc.sv
// Derives the next NZVC value from the adder outputs.
module addsub_flagcalc
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] sum,
    input  logic         c_into_msb,
    input  logic         c_out,
    input  logic         is_sub,
    input  logic         borrow_mode,
    output nzvc_t        flags
);

    always_comb begin
        flags.n = sum[W-1];
        flags.z = (sum == '0);
        flags.v = c_into_msb ^ c_out;
        flags.c = (is_sub && borrow_mode) ? ~c_out : c_out;
    end

endmodule

// File: rtl/addsub_nzvc.sv
// Top: registered adder-subtractor with NZVC status.
module addsub_nzvc
    import addsub_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [1:0]   op_code,
    input  logic         flag_we,
    input  logic         borrow_mode,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] result,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v,
    output logic         flag_c
);

    alu_op_e      op;
    logic [W-1:0] b_eff;
    logic         cin;
    logic         is_sub;
    logic [W-1:0] sum;
    logic         c_into_msb;
    logic         c_out;
    nzvc_t        flags_next;
    nzvc_t        flags_q;
    logic [W-1:0] result_q;

    assign op = alu_op_e'(op_code);

    addsub_opsel #(.W(W)) u_opsel (
        .op          (op),
        .opb         (opb),
        .c_flag      (flags_q.c),
        .borrow_mode (borrow_mode),
        .b_eff       (b_eff),
        .cin         (cin),
        .is_sub      (is_sub)
    );

    addsub_ripple #(.W(W)) u_ripple (
        .a          (opa),
        .b          (b_eff),
        .cin        (cin),
        .sum        (sum),
        .c_into_msb (c_into_msb),
        .c_out      (c_out)
    );

    addsub_flagcalc #(.W(W)) u_flags (
        .sum         (sum),
        .c_into_msb  (c_into_msb),
        .c_out       (c_out),
        .is_sub      (is_sub),
        .borrow_mode (borrow_mode),
        .flags       (flags_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (op_valid) begin
            result_q <= sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (op_valid && flag_we) begin
            flags_q <= flags_next;
        end
    end

    always_comb begin
        result = result_q;
        flag_n = flags_q.n;
        flag_z = flags_q.z;
        flag_v = flags_q.v;
        flag_c = flags_q.c;
    end

endmodule

// File: rtl/addsub_nzvc_chk.sv
// Port-level property checker, bound into the top module.
module addsub_nzvc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [1:0]   op_code,
    input logic         flag_we,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic [W-1:0] result,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_v,
    input logic         flag_c
);

    logic [W-1:0] exp_add;
    logic [W-1:0] exp_sub;
    logic [3:0]   flag_vec;

    assign exp_add  = opa + opb;
    assign exp_sub  = opa - opb;
    assign flag_vec = {flag_n, flag_z, flag_v, flag_c};

    // R1
    a_r1_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'b00) |=> (result == $past(exp_add)));

    // R2
    a_r2_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 2'b10) |=> (result == $past(exp_sub)));

    // R3
    a_r3_add_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we && op_code == 2'b00) |=>
        (flag_v == ($past(opa[W-1]) == $past(opb[W-1]) &&
                    result[W-1] != $past(opa[W-1]))));

    // R4
    a_r4_nz_track: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_we) |=>
        (flag_n == result[W-1] && flag_z == (result == '0)));

    // R7
    a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !flag_we) |=> $stable(flag_vec));

    // R8
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(result) && $stable(flag_vec)));

    // R9
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && flag_vec == 4'b0000));

endmodule

bind addsub_nzvc addsub_nzvc_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .flag_we  (flag_we),
    .opa      (opa),
    .opb      (opb),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c)
);

// File: tb/addsub_nzvc_test.sv
module addsub_nzvc_test;

    localparam int W    = 8;
    localparam int MODV = 2 ** W;
    localparam int HALF = 2 ** (W - 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_code = 2'b00;
    logic         flag_we = 1'b0;
    logic         borrow_mode = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic         flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int errors = 0;

    // bench model of the stored flags
    bit m_n, m_z, m_v, m_c;

    always #5 clk = ~clk;

    addsub_nzvc #(.W(W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .flag_we     (flag_we),
        .borrow_mode (borrow_mode),
        .opa         (opa),
        .opb         (opb),
        .result      (result),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_v      (flag_v),
        .flag_c      (flag_c)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_flags(string tag);
        chk({tag, " N"}, int'(flag_n), int'(m_n));
        chk({tag, " Z"}, int'(flag_z), int'(m_z));
        chk({tag, " V"}, int'(flag_v), int'(m_v));
        chk({tag, " C"}, int'(flag_c), int'(m_c));
    endtask

    function automatic int to_signed(int u);
        return (u >= HALF) ? u - MODV : u;
    endfunction

    // Issue one operation, model it arithmetically, check result and flags.
    task automatic run(string tag, logic [1:0] op, int a, int b, bit we);
        int ua, ub, sa, sb, u, s, extra, r;
        bit is_sub, borrow;
        ua = a % MODV;
        ub = b % MODV;
        sa = to_signed(ua);
        sb = to_signed(ub);
        is_sub = op[1];
        if (!is_sub) extra = (op == 2'b01) ? int'(m_c) : 0;
        else extra = (op == 2'b11) ? (borrow_mode ? int'(m_c) : int'(!m_c)) : 0;
        if (!is_sub) begin
            u = ua + ub + extra;
            s = sa + sb + extra;
        end else begin
            u = ua - ub - extra;
            s = sa - sb - extra;
        end
        r = ((u % MODV) + MODV) % MODV;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        opa      = ua[W-1:0];
        opb      = ub[W-1:0];
        flag_we  = we;
        @(negedge clk);
        op_valid = 1'b0;
        if (we) begin
            m_n = (r >= HALF);
            m_z = (r == 0);
            m_v = (s > HALF - 1) || (s < -HALF);
            if (!is_sub) m_c = (u >= MODV);
            else begin
                borrow = (u < 0);
                m_c = borrow_mode ? borrow : !borrow;
            end
        end
        chk({tag, " result"}, int'(result), r);
        check_flags(tag);
    endtask

    task automatic t_reset();
        m_n = 0; m_z = 0; m_v = 0; m_c = 0;
        chk("R9 reset result", int'(result), 0);
        check_flags("R9 reset");
    endtask

    task automatic t_add();
        run("R1 add plain", 2'b00, 8'h3C, 8'h15, 1'b1);
        run("R1 R4 add wrap to zero", 2'b00, 8'hFF, 8'h01, 1'b1);
        run("R3 add signed overflow", 2'b00, 8'h7F, 8'h01, 1'b1);
        run("R3 add neg overflow", 2'b00, 8'h80, 8'hFF, 1'b1);
    endtask

    task automatic t_sub();
        borrow_mode = 1'b0;
        run("R2 sub no borrow mode0", 2'b10, 5, 3, 1'b1);
        run("R2 sub borrow mode0", 2'b10, 3, 5, 1'b1);
        run("R2 R4 sub equal", 2'b10, 8'h42, 8'h42, 1'b1);
        run("R3 sub signed overflow", 2'b10, 8'h80, 8'h01, 1'b1);
        borrow_mode = 1'b1;
        run("R2 sub no borrow mode1", 2'b10, 5, 3, 1'b1);
        run("R2 sub borrow mode1", 2'b10, 3, 5, 1'b1);
        borrow_mode = 1'b0;
    endtask

    task automatic t_adc_chain();
        // 0x12FF + 0x0101 = 0x1400
        run("R5 low add", 2'b00, 8'hFF, 8'h01, 1'b1);
        run("R5 adc high", 2'b01, 8'h12, 8'h01, 1'b1);
        chk("R5 chained high word", int'(result), 8'h14);
        run("R5 adc no carry", 2'b01, 8'h10, 8'h01, 1'b1);
    endtask

    task automatic t_sbb_chain(bit mode);
        // 0x1000 - 0x0001 = 0x0FFF
        borrow_mode = mode;
        run(mode ? "R6 low sub mode1" : "R6 low sub mode0", 2'b10, 8'h00, 8'h01, 1'b1);
        run(mode ? "R6 sbb high mode1" : "R6 sbb high mode0", 2'b11, 8'h10, 8'h00, 1'b1);
        chk("R6 chained high word", int'(result), 8'h0F);
        run("R6 sbb no borrow in", 2'b11, 8'h20, 8'h01, 1'b1);
        borrow_mode = 1'b0;
    endtask

    task automatic t_no_flag_write();
        run("R7 set flags", 2'b00, 8'hF0, 8'h20, 1'b1);
        run("R7 flags kept", 2'b10, 8'h33, 8'h33, 1'b0);
    endtask

    task automatic t_idle_hold();
        int held;
        run("R8 prime", 2'b00, 8'h80, 8'h80, 1'b1);
        held = int'(result);
        @(negedge clk);
        opa = 8'h01; opb = 8'h02; op_code = 2'b10; flag_we = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 result held", int'(result), held);
        check_flags("R8 idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_adc_chain();
        t_sbb_chain(1'b0);
        t_sbb_chain(1'b1);
        t_no_flag_write();
        t_idle_hold();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule